// File: doc/BRIEF.md
# UART Receive Timeout and Data-Ready Interrupt Logic

This block sits beside the receive FIFO of a UART and decides when the receive side should interrupt the processor. It has two interrupt sources. The data-ready source asserts while the FIFO holds at least as many characters as a programmable trigger level. The timeout source catches a partly filled FIFO whose trickle of data has stopped. It asserts once the FIFO has held at least one character for four frame times with no new character arriving and no read.

A pending timeout is withdrawn by any of three events: a FIFO read, a FIFO flush, or the detection of a new start bit on the line. The start-bit case lets the request disappear before software reaches its handler, and the handler then finds no interrupt source. The serial deserializer and the FIFO storage are outside the block. It sees only the FIFO occupancy, strobes for character completion, start bit, read and flush, the trigger level and a bit-rate tick.

Top module: `uart_rx_tmo_irq`

## Requirements
- R1: With the FIFO empty (`fifo_level` = 0), no timeout is ever raised, whatever the number of bit ticks.
- R2: With the FIFO non-empty and the line idle, the timeout becomes pending on the 40th `bit_tick` after the last restart (frame of 10 bit ticks times 4 frames), and not before.
- R3: A pending timeout with `en_tmo` = 1 and no data-ready condition drives `irq` = 1 and `irq_id` = 2'b01.
- R4: A `fifo_rd` strobe clears a pending timeout, so `irq` falls in the cycle after the strobe, and it restarts the 40-tick count.
- R5: A `fifo_flush` strobe clears a pending timeout, so `irq` falls in the cycle after the strobe.
- R6: A `start_det` strobe clears a pending timeout in the cycle after it, even though software has not serviced it.
- R7: The timeout count holds at zero between `start_det` and the following `char_done`, so bit ticks during a frame never raise a timeout. `char_done` restarts the count.
- R8: The data-ready source is active exactly while `fifo_level` is non-zero and `fifo_level` >= `trig_level`. It is visible in `irq`/`irq_id` in the cycle after the level changes.
- R9: `irq_id` is 2'b10 when enabled data-ready is active, even if a timeout is also pending. Otherwise it is 2'b01 for an enabled pending timeout and 2'b00 for none. The value 2'b11 never appears.
- R10: `irq` is the OR of the two sources, each gated by its own enable (`en_rdy`, `en_tmo`). Disabling a source hides it without discarding a pending timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fifo_level | input | LVL_W | Current receive FIFO occupancy |
| char_done | input | 1 | One-cycle pulse: a character was written into the FIFO |
| start_det | input | 1 | One-cycle pulse: a start bit was detected on the line |
| fifo_rd | input | 1 | One-cycle pulse: software read the FIFO |
| fifo_flush | input | 1 | One-cycle pulse: software reset (emptied) the FIFO |
| trig_level | input | LVL_W | Data-ready trigger level |
| bit_tick | input | 1 | One pulse per serial bit time |
| en_tmo | input | 1 | Enable for the timeout source |
| en_rdy | input | 1 | Enable for the data-ready source |
| irq | output | 1 | Registered interrupt request |
| irq_id | output | 2 | Registered source code: 00 none, 01 timeout, 10 data ready |

## Verification
The hardest case to reach is the self-withdrawing timeout. A timeout must be pending and visible on `irq`, and a start bit must then arrive before any read, so the request vanishes with nothing having serviced it. The bench builds this case in order. It fills the FIFO below the trigger, counts exactly 40 ticks, and checks `irq` high with code 01. It then pulses `start_det` alone and checks that `irq` drops in the next cycle. It also checks that ticks during the frame that follows do not re-raise the timeout until `char_done` has restarted the count.

// File: rtl/uart_tmo_pkg.sv
package uart_tmo_pkg;
  typedef enum logic [1:0] {
    IID_NONE = 2'b00,
    IID_TMO  = 2'b01,
    IID_RDY  = 2'b10
  } iid_e;
endpackage

// File: rtl/rx_tmo_timer.sv
module rx_tmo_timer #(
  parameter int LVL_W       = 5,
  parameter int FRAME_TICKS = 10,
  parameter int CHAR_TIMES  = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LVL_W-1:0] fifo_level,
  input  logic             char_done,
  input  logic             start_det,
  input  logic             fifo_rd,
  input  logic             fifo_flush,
  input  logic             bit_tick,
  output logic             pend_nxt
);
  localparam int TMO_TICKS = FRAME_TICKS * CHAR_TIMES;
  localparam int TW        = $clog2(TMO_TICKS + 1);

  logic [TW-1:0] cnt;
  logic          busy;
  logic          pend;
  logic          empty, restart, clear, hit;

  assign empty   = (fifo_level == '0);
  assign restart = char_done | fifo_rd | fifo_flush | start_det | empty;
  assign clear   = fifo_rd | fifo_flush | start_det | empty;
  assign hit     = !restart && !busy && bit_tick && (cnt == TW'(TMO_TICKS - 1));
  assign pend_nxt = clear ? 1'b0 : (pend | hit);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      busy <= 1'b0;
      pend <= 1'b0;
    end else begin
      pend <= pend_nxt;
      if (start_det)      busy <= 1'b1;
      else if (char_done) busy <= 1'b0;
      if (restart || busy)
        cnt <= '0;
      else if (bit_tick && cnt != TW'(TMO_TICKS))
        cnt <= cnt + 1'b1;
    end
  end

  p_no_tmo_empty_r1: assert property (@(posedge clk) disable iff (rst)
    (fifo_level == '0) |=> !pend);
  p_clr_read_r4: assert property (@(posedge clk) disable iff (rst)
    fifo_rd |=> !pend);
  p_clr_flush_r5: assert property (@(posedge clk) disable iff (rst)
    fifo_flush |=> !pend);
  p_clr_start_r6: assert property (@(posedge clk) disable iff (rst)
    start_det |=> !pend);
  p_frame_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (busy && !char_done) |=> (cnt == '0));
endmodule

// File: rtl/rx_level_cmp.sv
module rx_level_cmp #(
  parameter int LVL_W = 5
) (
  input  logic [LVL_W-1:0] fifo_level,
  input  logic [LVL_W-1:0] trig_level,
  output logic             rdy
);
  assign rdy = (fifo_level != '0) && (fifo_level >= trig_level);
endmodule

// File: rtl/rx_irq_encode.sv
module rx_irq_encode
  import uart_tmo_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       rdy,
  input  logic       pend,
  input  logic       en_rdy,
  input  logic       en_tmo,
  output logic       irq,
  output logic [1:0] irq_id
);
  logic rdy_g, tmo_g;
  assign rdy_g = en_rdy & rdy;
  assign tmo_g = en_tmo & pend;

  always_ff @(posedge clk) begin
    if (rst) begin
      irq    <= 1'b0;
      irq_id <= IID_NONE;
    end else begin
      irq <= rdy_g | tmo_g;
      if (rdy_g)      irq_id <= IID_RDY;
      else if (tmo_g) irq_id <= IID_TMO;
      else            irq_id <= IID_NONE;
    end
  end

  p_id_legal_r9: assert property (@(posedge clk) disable iff (rst)
    irq_id != 2'b11);
  p_irq_has_id_r10: assert property (@(posedge clk) disable iff (rst)
    irq |-> (irq_id != IID_NONE));
endmodule

// File: rtl/uart_rx_tmo_irq.sv
module uart_rx_tmo_irq #(
  parameter int LVL_W       = 5,
  parameter int FRAME_TICKS = 10,
  parameter int CHAR_TIMES  = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LVL_W-1:0] fifo_level,
  input  logic             char_done,
  input  logic             start_det,
  input  logic             fifo_rd,
  input  logic             fifo_flush,
  input  logic [LVL_W-1:0] trig_level,
  input  logic             bit_tick,
  input  logic             en_tmo,
  input  logic             en_rdy,
  output logic             irq,
  output logic [1:0]       irq_id
);
  logic pend_nxt, rdy;

  rx_tmo_timer #(.LVL_W(LVL_W), .FRAME_TICKS(FRAME_TICKS), .CHAR_TIMES(CHAR_TIMES)) u_tmr (
    .clk(clk), .rst(rst), .fifo_level(fifo_level), .char_done(char_done),
    .start_det(start_det), .fifo_rd(fifo_rd), .fifo_flush(fifo_flush),
    .bit_tick(bit_tick), .pend_nxt(pend_nxt));

  rx_level_cmp #(.LVL_W(LVL_W)) u_cmp (
    .fifo_level(fifo_level), .trig_level(trig_level), .rdy(rdy));

  rx_irq_encode u_enc (
    .clk(clk), .rst(rst), .rdy(rdy), .pend(pend_nxt), .en_rdy(en_rdy),
    .en_tmo(en_tmo), .irq(irq), .irq_id(irq_id));

  p_rdy_prio_r8: assert property (@(posedge clk) disable iff (rst)
    (en_rdy && fifo_level != '0 && fifo_level >= trig_level) |=> (irq && irq_id == 2'b10));
  p_all_off_r10: assert property (@(posedge clk) disable iff (rst)
    (!en_rdy && !en_tmo) |=> !irq);
endmodule

// File: tb/sim_uart_rx_tmo_irq.sv
module sim_uart_rx_tmo_irq;
  localparam int CLK_PER = 10;
  localparam int LW = 5;
  localparam int TMO = 40;

  logic clk = 0, rst = 1;
  logic [LW-1:0] fifo_level = '0, trig_level = 5'd4;
  logic char_done = 0, start_det = 0, fifo_rd = 0, fifo_flush = 0, bit_tick = 0;
  logic en_tmo = 1, en_rdy = 1;
  logic irq;
  logic [1:0] irq_id;
  int total = 0, bad = 0;
  bit finished = 0;

  always #(CLK_PER/2) clk = ~clk;

  uart_rx_tmo_irq u0 (
    .clk(clk), .rst(rst), .fifo_level(fifo_level), .char_done(char_done),
    .start_det(start_det), .fifo_rd(fifo_rd), .fifo_flush(fifo_flush),
    .trig_level(trig_level), .bit_tick(bit_tick), .en_tmo(en_tmo),
    .en_rdy(en_rdy), .irq(irq), .irq_id(irq_id));

  task automatic chk(input logic e_irq, input logic [1:0] e_id, input string req);
    total++;
    if (irq !== e_irq || irq_id !== e_id) begin
      bad++;
      $display("FAIL %s: irq=%b id=%b expected irq=%b id=%b", req, irq, irq_id, e_irq, e_id);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
    char_done = 0; start_det = 0; fifo_rd = 0; fifo_flush = 0; bit_tick = 0;
  endtask

  task automatic ticks(input int n, input int gap);
    for (int i = 0; i < n; i++) begin
      bit_tick = 1; cyc();
      repeat (gap) cyc();
    end
  endtask

  task automatic add_char();
    char_done = 1; fifo_level = fifo_level + 1'b1; cyc();
  endtask

  initial begin
    repeat (3) cyc();
    rst = 0; cyc();
    chk(0, 2'b00, "reset");

    // R1: empty FIFO never times out
    ticks(100, 0);
    chk(0, 2'b00, "R1 empty");

    // R2/R3: exact 40-tick timeout, single tick spacing
    add_char();
    ticks(TMO - 1, 0);
    chk(0, 2'b00, "R2 before 40");
    ticks(1, 0);
    chk(1, 2'b01, "R2/R3 at 40");

    // R10: disable hides, pending kept
    en_tmo = 0; cyc();
    chk(0, 2'b00, "R10 masked");
    en_tmo = 1; cyc();
    chk(1, 2'b01, "R10 unmasked");

    // R4: read clears and restarts
    fifo_rd = 1; cyc();
    chk(0, 2'b00, "R4 read clears");
    ticks(TMO - 1, 2);
    chk(0, 2'b00, "R4 restart count");
    ticks(1, 2);
    chk(1, 2'b01, "R2 gap=2 at 40");

    // R6: start bit withdraws the pending timeout
    start_det = 1; cyc();
    chk(0, 2'b00, "R6 start clears");
    // R7: no counting during the frame
    ticks(100, 0);
    chk(0, 2'b00, "R7 hold in frame");
    add_char();
    ticks(TMO - 1, 0);
    chk(0, 2'b00, "R7 restart on char");
    ticks(1, 0);
    chk(1, 2'b01, "R7 fires after char");

    // R5: flush clears
    fifo_flush = 1; fifo_level = '0; cyc();
    chk(0, 2'b00, "R5 flush clears");
    ticks(60, 0);
    chk(0, 2'b00, "R5 stays clear");

    // R9: priority with both sources
    add_char();
    ticks(TMO, 0);
    chk(1, 2'b01, "R9 tmo only");
    trig_level = 5'd1; cyc();
    chk(1, 2'b10, "R9 rdy over tmo");
    en_rdy = 0; cyc();
    chk(1, 2'b01, "R10 rdy masked");
    en_rdy = 1; en_tmo = 0; fifo_rd = 1; fifo_level = '0; cyc();
    chk(0, 2'b00, "R4 read empties");

    // R8: level/trigger sweep, timeout disabled
    for (int t = 1; t <= 4; t++) begin
      for (int l = 0; l <= 5; l++) begin
        trig_level = LW'(t); fifo_level = LW'(l); cyc();
        if (l != 0 && l >= t) chk(1, 2'b10, "R8 sweep");
        else                  chk(0, 2'b00, "R8 sweep");
      end
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: run did not finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule